// File: doc/BRIEF.md
# Indexed RTC and CMOS Register Bank

This block holds a bank of byte-wide real-time-clock and battery-RAM registers behind a two-location byte bus. The even location is an index port: software writes the number of the register it wants and can read that number back. The odd location is a data port: it reads or writes whichever register the index currently selects. The index is 7 bits wide, so 128 locations are reachable. The locations above the control registers act as plain RAM.

Seven time-of-day registers are loaded from a parallel binary time input whenever its load strobe is high. These are seconds, minutes, hours, weekday, day of month, month and year. The input carries the weekday as 0..6 with Sunday as 0, the month as 0..11, and the year as years since 1900. A build-time parameter selects how the fields are stored: packed BCD, or plain binary. A freeze bit in control register B blocks these loads, so software can write a time and keep it. The block forces the data-mode bit of register B and the valid-time bit of register D. Interrupts and seconds counting live elsewhere.

Top module: `rtc_index_regs`

## Requirements
- R1: A bus write at address 0 latches wdata_i[6:0] as the index, and bit 7 is dropped. A bus read at address 0 returns {1'b0, index}.
- R2: A bus write at address 1 stores wdata_i in the location the index selects. A bus read at address 1 returns that location. Locations 14..127 hold any byte written to them unchanged.
- R3: Read data is registered. It appears on rdata_o at the clock edge that samples rd_i and holds until the next read.
- R4: With BCD_MODE=1, each loaded time field is stored as tens in bits 7:4 and units in bits 3:0. With BCD_MODE=0, it is stored as a plain binary value.
- R5: Bit 2 of register 11 (control B) always reads 0 when BCD_MODE=1 and 1 when BCD_MODE=0, whatever value was written to it.
- R6: Bit 7 of register 13 (control D, time valid) always reads 1.
- R7: A load with the freeze bit clear writes each time field to its register: seconds to 0, minutes to 2, hours to 4, weekday to 6, day of month to 7, month to 8, year to 9. The weekday is stored as input+1 (Sunday = 1) and the month as input+1 (1..12).
- R8: The year is stored modulo 100.
- R9: While bit 7 of register 11 (freeze) is 1, a load changes no register, and a value written by the bus to a time register is kept.
- R10: After reset, the index is 0, rdata_o is 0, and every location reads 0 except for the forced bits of R5 and R6.
- R11: If a bus data write and a load hit the same time register in the same cycle, the bus value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_i | input | 1 | Bus write strobe |
| rd_i | input | 1 | Bus read strobe |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Registered bus read data |
| ld_i | input | 1 | Time load strobe |
| ld_sec_i | input | 6 | Seconds 0..59 |
| ld_min_i | input | 6 | Minutes 0..59 |
| ld_hour_i | input | 5 | Hours 0..23 |
| ld_wday_i | input | 3 | Weekday 0..6, Sunday = 0 |
| ld_mday_i | input | 5 | Day of month 1..31 |
| ld_mon_i | input | 4 | Month 0..11 |
| ld_year_i | input | 8 | Years since 1900 |

## Verification
Each strobe takes effect at the next rising edge: index writes, data writes and loads all update state there. Read data is due on rdata_o at that same edge, one register after rd_i. The bench drives every strobe on a falling edge and holds it for one cycle. It checks rdata_o at the following falling edge, half a cycle after the update, so no check races the edge. Writes and loads are always followed by a separate read cycle before their effect is compared.

// File: rtl/rtc_idx_pkg.sv
package rtc_idx_pkg;
  localparam int unsigned OFS_SEC  = 0;
  localparam int unsigned OFS_MIN  = 2;
  localparam int unsigned OFS_HOUR = 4;
  localparam int unsigned OFS_WDAY = 6;
  localparam int unsigned OFS_MDAY = 7;
  localparam int unsigned OFS_MON  = 8;
  localparam int unsigned OFS_YEAR = 9;
  localparam int unsigned OFS_CTLB = 11;
  localparam int unsigned OFS_CTLD = 13;

  localparam int unsigned CTLB_FREEZE_BIT = 7;
  localparam int unsigned CTLB_BIN_BIT    = 2;
  localparam int unsigned CTLD_VALID_BIT  = 7;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] mday;
    logic [7:0] mon;
    logic [7:0] year;
  } tod_t;

  function automatic logic [7:0] bin2bcd(input logic [6:0] v);
    logic [6:0] tens, units;
    tens  = v / 7'd10;
    units = v % 7'd10;
    return {tens[3:0], units[3:0]};
  endfunction
endpackage

// File: rtl/rtc_tod_fmt.sv
module rtc_tod_fmt
  import rtc_idx_pkg::*;
#(
  parameter bit BCD_MODE = 1'b1
) (
  input  logic [5:0] sec_i,
  input  logic [5:0] min_i,
  input  logic [4:0] hour_i,
  input  logic [2:0] wday_i,
  input  logic [4:0] mday_i,
  input  logic [3:0] mon_i,
  input  logic [7:0] year_i,
  output tod_t       tod_o
);
  logic [6:0] sec_b, min_b, hour_b, wday_b, mday_b, mon_b, year_b;
  logic [7:0] year_mod;

  always_comb begin
    year_mod = year_i % 8'd100;
    sec_b    = {1'b0, sec_i};
    min_b    = {1'b0, min_i};
    hour_b   = {2'b0, hour_i};
    wday_b   = {4'b0, wday_i} + 7'd1;
    mday_b   = {2'b0, mday_i};
    mon_b    = {3'b0, mon_i} + 7'd1;
    year_b   = year_mod[6:0];
  end

  generate
    if (BCD_MODE) begin : g_bcd
      assign tod_o = '{sec: bin2bcd(sec_b), min: bin2bcd(min_b),
                       hour: bin2bcd(hour_b), wday: bin2bcd(wday_b),
                       mday: bin2bcd(mday_b), mon: bin2bcd(mon_b),
                       year: bin2bcd(year_b)};
    end else begin : g_bin
      assign tod_o = '{sec: {1'b0, sec_b}, min: {1'b0, min_b},
                       hour: {1'b0, hour_b}, wday: {1'b0, wday_b},
                       mday: {1'b0, mday_b}, mon: {1'b0, mon_b},
                       year: {1'b0, year_b}};
    end
  endgenerate
endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank
  import rtc_idx_pkg::*;
#(
  parameter int unsigned IDX_W    = 7,
  parameter bit          BCD_MODE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wr_data_i,
  input  logic             ld_i,
  input  tod_t             tod_i,
  output logic [7:0]       rd_data_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] IDX_CTLB = IDX_W'(OFS_CTLB);
  localparam logic [IDX_W-1:0] IDX_CTLD = IDX_W'(OFS_CTLD);

  logic [7:0] mem_q [DEPTH];
  logic       freeze;
  logic [7:0] wr_val;

  assign freeze = mem_q[OFS_CTLB][CTLB_FREEZE_BIT];

  always_comb begin
    wr_val = wr_data_i;
    if (idx_i == IDX_CTLB) wr_val[CTLB_BIN_BIT] = ~BCD_MODE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
      mem_q[OFS_CTLB][CTLB_BIN_BIT] <= ~BCD_MODE;
    end else begin
      if (ld_i && !freeze) begin
        mem_q[OFS_SEC]  <= tod_i.sec;
        mem_q[OFS_MIN]  <= tod_i.min;
        mem_q[OFS_HOUR] <= tod_i.hour;
        mem_q[OFS_WDAY] <= tod_i.wday;
        mem_q[OFS_MDAY] <= tod_i.mday;
        mem_q[OFS_MON]  <= tod_i.mon;
        mem_q[OFS_YEAR] <= tod_i.year;
      end
      // bus write placed last so it wins over a same-cycle load
      if (wr_en_i) mem_q[idx_i] <= wr_val;
    end
  end

  always_comb begin
    rd_data_o = mem_q[idx_i];
    if (idx_i == IDX_CTLD) rd_data_o[CTLD_VALID_BIT] = 1'b1;
  end
endmodule

// File: rtl/rtc_bus_port.sv
module rtc_bus_port #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [7:0]       wdata_i,
  input  logic [7:0]       reg_rdata_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             reg_wr_o,
  output logic [7:0]       rdata_o
);
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       rdata_q;

  assign idx_o    = idx_q;
  assign reg_wr_o = wr_i & addr_i;
  assign rdata_o  = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_i && !addr_i) idx_q <= wdata_i[IDX_W-1:0];
      if (rd_i) rdata_q <= addr_i ? reg_rdata_i : 8'(idx_q);
    end
  end
endmodule

// File: rtl/rtc_index_regs.sv
module rtc_index_regs
  import rtc_idx_pkg::*;
#(
  parameter int unsigned IDX_W    = 7,
  parameter bit          BCD_MODE = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       ld_i,
  input  logic [5:0] ld_sec_i,
  input  logic [5:0] ld_min_i,
  input  logic [4:0] ld_hour_i,
  input  logic [2:0] ld_wday_i,
  input  logic [4:0] ld_mday_i,
  input  logic [3:0] ld_mon_i,
  input  logic [7:0] ld_year_i
);
  logic [IDX_W-1:0] idx;
  logic             reg_wr;
  logic [7:0]       reg_rdata;
  tod_t             tod;

  rtc_bus_port #(.IDX_W(IDX_W)) u_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
    .rd_i(rd_i), .wdata_i(wdata_i), .reg_rdata_i(reg_rdata),
    .idx_o(idx), .reg_wr_o(reg_wr), .rdata_o(rdata_o)
  );

  rtc_tod_fmt #(.BCD_MODE(BCD_MODE)) u_fmt (
    .sec_i(ld_sec_i), .min_i(ld_min_i), .hour_i(ld_hour_i),
    .wday_i(ld_wday_i), .mday_i(ld_mday_i), .mon_i(ld_mon_i),
    .year_i(ld_year_i), .tod_o(tod)
  );

  rtc_reg_bank #(.IDX_W(IDX_W), .BCD_MODE(BCD_MODE)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(reg_wr), .idx_i(idx),
    .wr_data_i(wdata_i), .ld_i(ld_i), .tod_i(tod), .rd_data_o(reg_rdata)
  );
endmodule

// File: rtl/rtc_index_regs_chk.sv
module rtc_index_regs_chk #(
  parameter int unsigned IDX_W    = 7,
  parameter bit          BCD_MODE = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             addr_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [IDX_W-1:0] wdata_idx_i,
  input logic [7:0]       rdata_i,
  input logic [IDX_W-1:0] idx_i
);
  // R1
  idx_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i) |=> (idx_i == $past(wdata_idx_i)));

  // R1
  idx_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !addr_i) |=> (rdata_i == 8'($past(idx_i))));

  // R3
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_i));

  // R5
  mode_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i && idx_i == IDX_W'(11)) |=> (rdata_i[2] == !BCD_MODE));

  // R6
  valid_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i && idx_i == IDX_W'(13)) |=> rdata_i[7]);
endmodule

bind rtc_index_regs rtc_index_regs_chk #(.IDX_W(IDX_W), .BCD_MODE(BCD_MODE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .wdata_idx_i(wdata_i[IDX_W-1:0]), .rdata_i(rdata_o), .idx_i(idx)
);

// File: tb/sim_rtc_index_regs.sv
module sim_rtc_index_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, wr = 1'b0, rd = 1'b0, ld = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [5:0] l_sec = '0, l_min = '0;
  logic [4:0] l_hour = '0, l_mday = '0;
  logic [2:0] l_wday = '0;
  logic [3:0] l_mon = '0;
  logic [7:0] l_year = '0;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0] m [128];
  logic [6:0] midx;

  always #2 clk = ~clk;

  rtc_index_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .ld_i(ld), .ld_sec_i(l_sec),
    .ld_min_i(l_min), .ld_hour_i(l_hour), .ld_wday_i(l_wday),
    .ld_mday_i(l_mday), .ld_mon_i(l_mon), .ld_year_i(l_year)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] model_read(input bit a);
    logic [7:0] v;
    if (!a) return {1'b0, midx};
    v = m[midx];
    if (midx == 7'd13) v[7] = 1'b1;
    return v;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input bit a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    if (!a) midx = d[6:0];
    else m[midx] = (midx == 7'd11) ? (d & 8'hFB) : d;
  endtask

  task automatic bus_rd(input bit a, input string req);
    logic [7:0] exp;
    exp = model_read(a);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check(req, rdata, exp);
  endtask

  task automatic do_load(input int s, input int mi, input int h, input int wd,
                         input int md, input int mo, input int y,
                         input bit with_wr, input logic [7:0] wv);
    @(negedge clk);
    l_sec = 6'(s); l_min = 6'(mi); l_hour = 5'(h); l_wday = 3'(wd);
    l_mday = 5'(md); l_mon = 4'(mo); l_year = 8'(y); ld = 1'b1;
    if (with_wr) begin addr = 1'b1; wr = 1'b1; wdata = wv; end
    @(negedge clk);
    ld = 1'b0; wr = 1'b0;
    if (!m[11][7]) begin
      m[0] = bcd(s); m[2] = bcd(mi); m[4] = bcd(h); m[6] = bcd(wd + 1);
      m[7] = bcd(md); m[8] = bcd(mo + 1); m[9] = bcd(y % 100);
    end
    if (with_wr) m[midx] = (midx == 7'd11) ? (wv & 8'hFB) : wv;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) m[i] = 8'h00;
    midx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    check("R10 rdata", rdata, 8'h00);
    bus_rd(1'b0, "R10 index");
    bus_rd(1'b1, "R10 reg0");
    bus_wr(1'b0, 8'd11); bus_rd(1'b1, "R10 R5 ctlB");
    bus_wr(1'b0, 8'd13); bus_rd(1'b1, "R10 R6 ctlD");
    bus_wr(1'b1, 8'h00); bus_rd(1'b1, "R6 ctlD after write 0");

    // R1 bit 7 of index dropped
    bus_wr(1'b0, 8'h85); bus_rd(1'b0, "R1 index readback");
    check("R1 index value", rdata, 8'h05);

    // R2 RAM
    bus_wr(1'b0, 8'd20); bus_wr(1'b1, 8'h5A); bus_rd(1'b1, "R2 ram20");
    bus_wr(1'b0, 8'd127); bus_wr(1'b1, 8'hC3); bus_rd(1'b1, "R2 ram127");

    // R3 hold
    repeat (3) @(negedge clk);
    check("R3 hold", rdata, 8'hC3);

    // R5 forced mode bit
    bus_wr(1'b0, 8'd11); bus_wr(1'b1, 8'h7F); bus_rd(1'b1, "R5 ctlB");
    check("R5 ctlB value", rdata, 8'h7B);
    bus_wr(1'b1, 8'h00);

    // R4 R7 R8 load
    do_load(59, 7, 23, 6, 31, 11, 125, 1'b0, 8'h00);
    for (int k = 0; k < 10; k++) begin
      bus_wr(1'b0, 8'(k)); bus_rd(1'b1, "R4 R7 R8 time field");
    end
    bus_wr(1'b0, 8'd0); bus_rd(1'b1, "R4 sec"); check("R4 sec bcd", rdata, 8'h59);
    bus_wr(1'b0, 8'd6); bus_rd(1'b1, "R7 wday"); check("R7 wday", rdata, 8'h07);
    bus_wr(1'b0, 8'd8); bus_rd(1'b1, "R7 mon"); check("R7 mon", rdata, 8'h12);
    bus_wr(1'b0, 8'd9); bus_rd(1'b1, "R8 year"); check("R8 year", rdata, 8'h25);

    // R9 freeze
    bus_wr(1'b0, 8'd11); bus_wr(1'b1, 8'h80);
    bus_wr(1'b0, 8'd0); bus_wr(1'b1, 8'h33);
    do_load(12, 34, 5, 1, 2, 3, 99, 1'b0, 8'h00);
    bus_rd(1'b1, "R9 sec held"); check("R9 sec value", rdata, 8'h33);
    bus_wr(1'b0, 8'd2); bus_rd(1'b1, "R9 min unchanged");
    check("R9 min value", rdata, 8'h07);

    // R11 collision, freeze cleared
    bus_wr(1'b0, 8'd11); bus_wr(1'b1, 8'h00);
    bus_wr(1'b0, 8'd0);
    do_load(10, 20, 3, 0, 1, 0, 100, 1'b1, 8'h44);
    bus_rd(1'b1, "R11 bus wins"); check("R11 sec value", rdata, 8'h44);
    bus_wr(1'b0, 8'd2); bus_rd(1'b1, "R11 other field loaded");
    bus_wr(1'b0, 8'd6); bus_rd(1'b1, "R7 sunday"); check("R7 sunday", rdata, 8'h01);
    bus_wr(1'b0, 8'd9); bus_rd(1'b1, "R8 year 2000"); check("R8 year 00", rdata, 8'h00);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0: bus_wr(1'b0, 8'($urandom));
        1: bus_wr(1'b0, 8'($urandom % 16));
        2: bus_wr(1'b1, 8'($urandom));
        3: bus_rd(1'b0, "R1 random index read");
        4: bus_rd(1'b1, "R2 R5 R9 random data read");
        default: do_load(int'($urandom % 60), int'($urandom % 60), int'($urandom % 24),
                         int'($urandom % 7), int'($urandom % 31) + 1, int'($urandom % 12),
                         int'($urandom % 256), 1'($urandom % 2), 8'($urandom));
      endcase
    end
    for (int k = 0; k < 14; k++) begin
      bus_wr(1'b0, 8'(k)); bus_rd(1'b1, "R7 R9 final sweep");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule